// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical frame number by reading two levels of translation tables held in memory. A requester, normally a translation cache that has just missed, hands over the upper 20 bits of a 32-bit virtual address. The walker then performs two dependent word reads. The first fetches a directory entry, located from a root address register. The second fetches a table entry, located from the frame that the directory entry names. It returns the resulting frame number, or a fault if either entry is not marked present.

The virtual address is divided into three fields. Bits 31:22 index the directory, bits 21:12 index the page table, and bits 11:0 are the byte offset within the page. The requester forms the final physical address itself, by placing the returned frame above the offset. Each table has 1024 four-byte entries, so one page table maps 4 MB and the directory spans the full 4 GB. Only one walk is in flight at a time. The memory port carries one outstanding word read.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready_o` is 1, and both `mem_req_o` and `rsp_valid_o` are 0.
- R2: The first memory read of a walk goes to the root address plus 4 times VPN bits 19:10 (virtual address bits 31:22). The root address is taken from `base_i` in the cycle the request is accepted.
- R3: When the directory entry has bit 0 (present) set, the second read goes to {entry[31:12], 12'h000} plus 4 times VPN bits 9:0 (virtual address bits 21:12). Entry bits 11:1 are ignored.
- R4: When the directory entry has bit 0 clear, the walk issues no second read. It responds with `rsp_fault_o`=1 and `rsp_pfn_o`=0.
- R5: When the table entry has bit 0 clear, the response has `rsp_fault_o`=1 and `rsp_pfn_o`=0.
- R6: When both entries are present, the response has `rsp_fault_o`=0 and `rsp_pfn_o` equal to table entry bits 31:12.
- R7: While a read is outstanding, `mem_req_o` stays high and `mem_addr_o` stays stable until `mem_rvalid_i` arrives. A `mem_rvalid_i` pulse while no read is outstanding has no effect.
- R8: From acceptance until the response, `req_ready_o` is 0. Further requests and changes to `base_i` in that time have no effect on the walk.
- R9: `rsp_valid_o` is a one-cycle pulse. It rises in the cycle after the clock edge that consumes the final `mem_rvalid_i`, and the walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_i | input | 32 | Physical address of the directory |
| req_valid_i | input | 1 | Walk request |
| req_vpn_i | input | 20 | Virtual page number (VA bits 31:12) |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| mem_req_o | output | 1 | Word read outstanding |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Walk hit a non-present entry |
| rsp_pfn_o | output | 20 | Translated frame number |

## Verification
A wrong state or a stale latched value shows up at the ports within the same walk. Wrong indexing or a mishandled base shows as a wrong address on the memory port in the first or second read. A wrong present decision shows as a missing or extra table read, visible before the response. A mishandled entry shows as a wrong frame or fault flag on the response pulse. A state that fails to return to idle shows as `req_ready_o` staying low, or as a response pulse longer than one cycle, on the very next cycle. The sweep covers every directory index, with varied table indices and memory latencies, so that both fault sources and the success path are each hit hundreds of times.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic                        req_valid_i,
  input  logic [2*IDX_W-1:0]          req_vpn_i,
  output logic                        req_ready_o,
  output logic                        mem_req_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  input  logic                        mem_rvalid_i,
  input  logic [ADDR_W-1:0]           mem_rdata_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_fault_o,
  output logic [ADDR_W-OFF_W-1:0]     rsp_pfn_o
);
  localparam int VPN_W  = 2 * IDX_W;
  localparam int PFN_W  = ADDR_W - OFF_W;
  localparam int ENT_SH = 2;
  localparam int PAD_W  = ADDR_W - IDX_W - ENT_SH;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_DONE} st_t;

  st_t               st;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [PFN_W-1:0]  tbl_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              fault_q;

  logic [IDX_W-1:0]  dir_idx, tbl_idx;
  logic [ADDR_W-1:0] dir_addr, tbl_addr;
  logic              present;
  logic [PFN_W-1:0]  next_frame;

  assign dir_idx    = vpn_q[VPN_W-1:IDX_W];
  assign tbl_idx    = vpn_q[IDX_W-1:0];
  assign dir_addr   = base_q + {{PAD_W{1'b0}}, dir_idx, {ENT_SH{1'b0}}};
  assign tbl_addr   = {tbl_q, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tbl_idx, {ENT_SH{1'b0}}};
  assign present    = mem_rdata_i[0];
  assign next_frame = mem_rdata_i[ADDR_W-1:OFF_W];

  assign req_ready_o = (st == S_IDLE);
  assign mem_req_o   = (st == S_DIR) || (st == S_TBL);
  assign mem_addr_o  = (st == S_TBL) ? tbl_addr : dir_addr;
  assign rsp_valid_o = (st == S_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_pfn_o   = pfn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      pfn_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vpn_i;
          base_q  <= base_i;
          pfn_q   <= '0;
          fault_q <= 1'b0;
          st      <= S_DIR;
        end
        S_DIR: if (mem_rvalid_i) begin
          if (present) begin
            tbl_q <= next_frame;
            st    <= S_TBL;
          end else begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end
        end
        S_TBL: if (mem_rvalid_i) begin
          if (present) pfn_q <= next_frame;
          else         fault_q <= 1'b1;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && mem_req_o));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  assert_rsp_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(mem_rvalid_i));

  assert_fault_no_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pfn_o == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam logic [31:0] BASE  = 32'h0004_0000;
  localparam logic [19:0] TBASE = 20'h00100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = BASE;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_vpn_i = '0;
  logic        req_ready_o, mem_req_o, rsp_valid_o, rsp_fault_o;
  logic [31:0] mem_addr_o;
  logic [19:0] rsp_pfn_o;
  logic        mdl_rvalid = 1'b0, stray = 1'b0;
  logic [31:0] mdl_rdata = '0;
  logic        mem_rvalid_i;

  int checks = 0, failures = 0, cycles = 0;
  int cur_lat = 0, wait_cnt = 0, acc_cnt = 0;
  bit pending = 0, unstable = 0, done = 0;
  logic [31:0] hold_addr = '0;
  logic [31:0] acc_addr [2];

  assign mem_rvalid_i = mdl_rvalid | stray;

  always #2 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .base_i(base_i),
    .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_ready_o(req_ready_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mdl_rdata),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_pfn_o(rsp_pfn_o)
  );

  function automatic bit dir_present(int d);
    return (d % 5) != 3;
  endfunction
  function automatic bit tbl_present(int d, int t);
    return ((d + t) % 7) != 0;
  endfunction
  function automatic logic [19:0] frame_of(int d, int t);
    return 20'((d << 10) | t) ^ 20'h5A5A5;
  endfunction

  function automatic logic [31:0] lookup(logic [31:0] a);
    int d, t;
    if (a[31:12] == BASE[31:12]) begin
      d = int'(a[11:2]);
      return {TBASE + 20'(d), 11'h2A6, dir_present(d)};
    end else if (a[31:12] >= TBASE && a[31:12] < TBASE + 20'd1024) begin
      d = int'(a[31:12] - TBASE);
      t = int'(a[11:2]);
      return {frame_of(d, t), 11'h155, tbl_present(d, t)};
    end
    return 32'hDEAD_BEE0;
  endfunction

  always @(negedge clk) begin
    if (mdl_rvalid) begin
      mdl_rvalid = 1'b0;
      pending = 0;
    end else if (mem_req_o) begin
      if (!pending) begin
        pending = 1;
        hold_addr = mem_addr_o;
        wait_cnt = cur_lat;
      end
      if (mem_addr_o != hold_addr) unstable = 1;
      if (wait_cnt == 0) begin
        mdl_rvalid = 1'b1;
        mdl_rdata = lookup(mem_addr_o);
        if (acc_cnt < 2) acc_addr[acc_cnt] = mem_addr_o;
        acc_cnt++;
      end else wait_cnt--;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_walk(logic [19:0] vpn, int lat, bit disturb);
    int d = int'(vpn[19:10]);
    int t = int'(vpn[9:0]);
    bit dp = dir_present(d);
    bit tp = tbl_present(d, t);
    bit ok = dp && tp;
    int cyc = 0;
    @(negedge clk);
    cur_lat = lat; acc_cnt = 0; unstable = 0;
    req_valid_i = 1'b1; req_vpn_i = vpn; base_i = BASE;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (disturb) begin
      chk(req_ready_o == 1'b0, "R8", "ready while busy", {31'b0, req_ready_o}, 32'd0);
      req_valid_i = 1'b1; req_vpn_i = ~vpn; base_i = 32'h0BAD_0000;
    end
    while (!rsp_valid_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    req_valid_i = 1'b0; base_i = BASE;
    chk(rsp_valid_o == 1'b1, "R9", "response timeout", {31'b0, rsp_valid_o}, 32'd1);
    chk(acc_addr[0] == BASE + 32'(d * 4), "R2", "directory address", acc_addr[0], BASE + 32'(d * 4));
    chk(acc_cnt == (dp ? 2 : 1), "R4", "read count", 32'(acc_cnt), dp ? 32'd2 : 32'd1);
    if (dp)
      chk(acc_addr[1] == {TBASE + 20'(d), 12'h000} + 32'(t * 4), "R3", "table address",
          acc_addr[1], {TBASE + 20'(d), 12'h000} + 32'(t * 4));
    chk(!unstable, "R7", "address held while waiting", {31'b0, unstable}, 32'd0);
    chk(rsp_fault_o == !ok, dp ? "R5" : "R4", "fault flag", {31'b0, rsp_fault_o}, {31'b0, !ok});
    chk(rsp_pfn_o == (ok ? frame_of(d, t) : 20'h0), "R6", "frame", {12'b0, rsp_pfn_o},
        {12'b0, ok ? frame_of(d, t) : 20'h0});
    @(negedge clk);
    chk(!rsp_valid_o && req_ready_o, "R9", "pulse ends, ready again",
        {30'b0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1", "reset state",
        {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1", "idle after reset",
        {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);

    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R7", "stray rvalid ignored",
        {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);

    do_walk({10'd1, 10'd2}, 0, 1'b0);
    do_walk({10'd3, 10'd9}, 2, 1'b0);
    do_walk({10'd0, 10'd0}, 1, 1'b0);
    do_walk({10'd1023, 10'd1023}, 3, 1'b1);
    do_walk({10'd6, 10'd1}, 2, 1'b1);
    do_walk({10'd8, 10'd5}, 1, 1'b1);

    for (int d = 0; d < 1024; d++) begin
      do_walk({10'(d), 10'(d)}, d % 4, 1'b0);
      do_walk({10'(d), 10'((d * 37 + 5) % 1024)}, (d + 1) % 4, d % 9 == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule